// File: doc/BRIEF.md
# Address Decoder with Reset Remap

This block turns the 16-bit address of a small 8-bit single-board computer into one chip select per on-board device. It also reports the offset of the access inside the selected device. The devices are program RAM at the bottom of the space, a monitor ROM just below the 32 KB boundary, a small RAM at the very top that holds the interrupt vectors, a row of parallel-port adapter slots, and the register window of a combined timer and I/O chip. The decoder is purely combinational.

The vector RAM is volatile, so it holds nothing useful at power-up. While reset is held low, the decoder forces the effective top address bit to zero. A reset-vector fetch at the top of the space is then served by the ROM, which holds the matching bytes 32 KB lower. The I/O window leaves two address bits undecoded, so it appears four times in the space. Address bit 3 is not part of the register number. It travels beside the select as a qualifier that tells the timer whether to enable its interrupt.

Top module: `memmap_dec`

## Requirements
- R1: An effective address in 0x0000..0x01FF asserts `ram_cs_o`, and `off_o` equals the address bits [8:0].
- R2: An effective address in 0x7C00..0x7FFF asserts `rom_cs_o` with `off_o` = address bits [9:0] only when `rd_i`=1 (read). A write (`rd_i`=0) there asserts no select and raises `unmapped_o`.
- R3: With `rst_ni`=1, an address in 0xFFC0..0xFFFF asserts `vec_cs_o`, and `off_o` equals the address bits [5:0].
- R4: With `rst_ni`=0, bit 15 of the address is treated as 0 for all decoding. A read of 0xFFFC selects the ROM with `off_o`=0x3FC, and `vec_cs_o` is never asserted.
- R5: `eff_a15_o` equals `addr_i[15]` when `rst_ni`=1 and is 0 when `rst_ni`=0. It follows a change of reset without waiting for a clock edge.
- R6: Adapter slot k (k = 0..7) occupies 0x4000+4k..0x4003+4k. Only bit k of `pia_cs_o` is asserted, and `off_o` equals the address bits [1:0]. 0x4020 and above select no slot.
- R7: The I/O window decodes when bits [15:12] = 0x6 and bits [9:4] = 0x20, with bits [11:10] ignored. This gives aliases at 0x6200, 0x6600, 0x6A00 and 0x6E00. It asserts `mio_cs_o`, `off_o` equals the address bits [2:0], and `irq_en_o` equals address bit 3. `irq_en_o` is 0 for every other access.
- R8: At most one select is asserted at any time. `unmapped_o` is 1 exactly when none is asserted, and `off_o` is then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low reset; while low, address bit 15 is forced to 0 |
| addr_i | input | 16 | CPU address bus |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| ram_cs_o | output | 1 | Program RAM select |
| rom_cs_o | output | 1 | Monitor ROM select (reads only) |
| vec_cs_o | output | 1 | Interrupt-vector RAM select |
| mio_cs_o | output | 1 | Timer/I/O register window select |
| pia_cs_o | output | 8 | One-hot adapter slot select |
| irq_en_o | output | 1 | Interrupt-enable qualifier (address bit 3) for the I/O window |
| unmapped_o | output | 1 | No device selected |
| off_o | output | 10 | Offset within the selected device |
| eff_a15_o | output | 1 | Effective address bit 15 after the reset remap |

## Verification
The reset remap and the top-window decode meet on the same addresses. When reset is low, a read of the vector area must land in the ROM, and any upper-half address must decode as its lower-half twin. The bench provokes this by sweeping the whole address space for reads and writes, once with reset high and once with reset low. It judges each result against a range-based model written from the requirements. It then releases reset while 0xFFFD is held on the bus and confirms that the select moves from ROM to vector RAM without any clock edge.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 10;

  // base/size window test; size must be a power of two
  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] base,
                                  input int unsigned size);
    logic [ADDR_W-1:0] msk;
    msk = ~ADDR_W'(size - 1);
    return (a & msk) == (base & msk);
  endfunction
endpackage

// File: rtl/memdec_remap.sv
module memdec_remap
  import memdec_pkg::*;
(
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_o
);
  // top bit held low during reset so vector fetches fall into ROM
  assign eff_o = {addr_i[ADDR_W-1] & rst_ni, addr_i[ADDR_W-2:0]};
endmodule

// File: rtl/memdec_window.sv
module memdec_window
  import memdec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int unsigned       SIZE = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = in_win(addr_i, BASE, SIZE);
endmodule

// File: rtl/memdec_mio.sv
module memdec_mio
  import memdec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK  = 16'hF3F0,
  parameter logic [ADDR_W-1:0] MATCH = 16'h6200
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  // bits outside MASK (alias bits and register/qualifier bits) are don't-care
  assign hit_o = (addr_i & MASK) == (MATCH & MASK);
endmodule

// File: rtl/memmap_dec.sv
module memmap_dec
  import memdec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h0000,
  parameter int unsigned       RAM_BYTES = 512,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h7C00,
  parameter int unsigned       ROM_BYTES = 1024,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFC0,
  parameter int unsigned       VEC_BYTES = 64,
  parameter logic [ADDR_W-1:0] PIA_BASE  = 16'h4000,
  parameter int unsigned       PIA_SLOTS = 8,
  parameter int unsigned       PIA_REGS  = 4,
  parameter logic [ADDR_W-1:0] MIO_MASK  = 16'hF3F0,
  parameter logic [ADDR_W-1:0] MIO_MATCH = 16'h6200
) (
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  output logic                 ram_cs_o,
  output logic                 rom_cs_o,
  output logic                 vec_cs_o,
  output logic                 mio_cs_o,
  output logic [PIA_SLOTS-1:0] pia_cs_o,
  output logic                 irq_en_o,
  output logic                 unmapped_o,
  output logic [OFF_W-1:0]     off_o,
  output logic                 eff_a15_o
);
  localparam int unsigned MIO_REGS = 8;
  localparam logic [ADDR_W-1:0] RAM_M = ADDR_W'(RAM_BYTES - 1);
  localparam logic [ADDR_W-1:0] ROM_M = ADDR_W'(ROM_BYTES - 1);
  localparam logic [ADDR_W-1:0] VEC_M = ADDR_W'(VEC_BYTES - 1);
  localparam logic [ADDR_W-1:0] PIA_M = ADDR_W'(PIA_REGS - 1);
  localparam logic [ADDR_W-1:0] MIO_M = ADDR_W'(MIO_REGS - 1);

  logic [ADDR_W-1:0]    eff;
  logic                 ram_hit, rom_hit, vec_hit, mio_hit;
  logic [PIA_SLOTS-1:0] pia_hit;

  memdec_remap u_remap (.rst_ni(rst_ni), .addr_i(addr_i), .eff_o(eff));

  memdec_window #(.BASE(RAM_BASE), .SIZE(RAM_BYTES)) u_ram (.addr_i(eff), .hit_o(ram_hit));
  memdec_window #(.BASE(ROM_BASE), .SIZE(ROM_BYTES)) u_rom (.addr_i(eff), .hit_o(rom_hit));
  memdec_window #(.BASE(VEC_BASE), .SIZE(VEC_BYTES)) u_vec (.addr_i(eff), .hit_o(vec_hit));

  for (genvar k = 0; k < PIA_SLOTS; k++) begin : g_pia
    localparam logic [ADDR_W-1:0] SLOT_BASE = PIA_BASE + ADDR_W'(k * PIA_REGS);
    memdec_window #(.BASE(SLOT_BASE), .SIZE(PIA_REGS)) u_slot (
      .addr_i(eff), .hit_o(pia_hit[k]));
  end

  memdec_mio #(.MASK(MIO_MASK), .MATCH(MIO_MATCH)) u_mio (.addr_i(eff), .hit_o(mio_hit));

  assign ram_cs_o   = ram_hit;
  assign rom_cs_o   = rom_hit & rd_i;  // ROM ignores writes
  assign vec_cs_o   = vec_hit;
  assign mio_cs_o   = mio_hit;
  assign pia_cs_o   = pia_hit;
  assign irq_en_o   = mio_hit & eff[3];
  assign unmapped_o = ~(ram_hit | (rom_hit & rd_i) | vec_hit | mio_hit | (|pia_hit));
  assign eff_a15_o  = eff[ADDR_W-1];

  always_comb begin
    logic [ADDR_W-1:0] o;
    o = '0;
    if (ram_hit)               o = eff & RAM_M;
    else if (rom_hit && rd_i)  o = eff & ROM_M;
    else if (vec_hit)          o = eff & VEC_M;
    else if (mio_hit)          o = eff & MIO_M;
    else if (|pia_hit)         o = eff & PIA_M;
    off_o = o[OFF_W-1:0];
  end

  always_comb begin
    a_r8_one_select: assert ($onehot0({ram_cs_o, rom_cs_o, vec_cs_o, mio_cs_o, pia_cs_o}));
    a_r8_unmapped_excl: assert (unmapped_o != (ram_cs_o | rom_cs_o | vec_cs_o | mio_cs_o | (|pia_cs_o)));
    if (!rst_ni) a_r4_no_vec_in_reset: assert (!vec_cs_o && !eff_a15_o);
    if (!rd_i) a_r2_rom_read_only: assert (!rom_cs_o);
    if (irq_en_o) a_r7_irq_qual: assert (mio_cs_o);
    if (unmapped_o) a_r8_off_zero: assert (off_o == '0);
  end
endmodule

// File: tb/tb_memmap_dec.sv
module tb_memmap_dec;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic        rn;
    logic        rd;
    logic [15:0] a;
    logic [3:0]  dev;   // 0 none,1 ram,2 rom,3 vec,4 mio,5 pia
    logic [2:0]  slot;
    logic [9:0]  off;
    logic        irq;
    logic        eff;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 16'h0000, 4'd1, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h01FF, 4'd1, 3'd0, 10'h1FF, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h0200, 4'd0, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h7C00, 4'd2, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h7FFD, 4'd2, 3'd0, 10'h3FD, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h7C10, 4'd0, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'hFFFC, 4'd3, 3'd0, 10'h03C, 1'b0, 1'b1},
    '{1'b0, 1'b1, 16'hFFFC, 4'd2, 3'd0, 10'h3FC, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'hFFC0, 4'd2, 3'd0, 10'h3C0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h4000, 4'd5, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h401F, 4'd5, 3'd7, 10'h003, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h4020, 4'd0, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h6200, 4'd4, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h6E0D, 4'd4, 3'd0, 10'h005, 1'b1, 1'b0},
    '{1'b1, 1'b1, 16'h6A07, 4'd4, 3'd0, 10'h007, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h6210, 4'd0, 3'd0, 10'h000, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'hC001, 4'd5, 3'd0, 10'h001, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h8000, 4'd0, 3'd0, 10'h000, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] addr_i;
  logic        rd_i;
  logic        ram_cs_o, rom_cs_o, vec_cs_o, mio_cs_o, irq_en_o, unmapped_o, eff_a15_o;
  logic [7:0]  pia_cs_o;
  logic [9:0]  off_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_dec dut (
    .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
    .ram_cs_o(ram_cs_o), .rom_cs_o(rom_cs_o), .vec_cs_o(vec_cs_o),
    .mio_cs_o(mio_cs_o), .pia_cs_o(pia_cs_o), .irq_en_o(irq_en_o),
    .unmapped_o(unmapped_o), .off_o(off_o), .eff_a15_o(eff_a15_o));

  function automatic string tag_of(input logic [3:0] dev, input logic rn, input logic rd,
                                   input logic [15:0] a);
    if (!rn && a[15]) return "R4";
    case (dev)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R7";
      4'd5: return "R6";
      default: return (!rd && a >= 16'h7C00 && a <= 16'h7FFF) ? "R2" : "R8";
    endcase
  endfunction

  // reference map written from the requirement ranges
  task automatic model(input logic rn, input logic rd, input logic [15:0] a,
                       output vec_t v);
    logic [15:0] e;
    e = rn ? a : (a & 16'h7FFF);
    v = '0;
    v.rn = rn; v.rd = rd; v.a = a; v.eff = e[15];
    if (e <= 16'h01FF) begin
      v.dev = 4'd1; v.off = 10'(e);
    end else if (e >= 16'h7C00 && e <= 16'h7FFF) begin
      if (rd) begin v.dev = 4'd2; v.off = 10'(e - 16'h7C00); end
    end else if (e >= 16'hFFC0) begin
      v.dev = 4'd3; v.off = 10'(e - 16'hFFC0);
    end else if (e >= 16'h4000 && e <= 16'h401F) begin
      v.dev = 4'd5; v.slot = 3'((e - 16'h4000) / 4); v.off = 10'(e % 4);
    end else if (e[15:12] == 4'h6 && e[9:4] == 6'h20) begin
      v.dev = 4'd4; v.off = 10'(e[2:0]); v.irq = e[3];
    end
  endtask

  task automatic check(input vec_t v, input string tag);
    logic [24:0] got, exp;
    logic [7:0] ep;
    ep = (v.dev == 4'd5) ? (8'b1 << v.slot) : 8'h00;
    got = {ram_cs_o, rom_cs_o, vec_cs_o, mio_cs_o, pia_cs_o, irq_en_o, unmapped_o, off_o, eff_a15_o};
    exp = {v.dev == 4'd1, v.dev == 4'd2, v.dev == 4'd3, v.dev == 4'd4, ep, v.irq,
           v.dev == 4'd0, v.off, v.eff};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s rst_n=%0b rd=%0b addr=%h actual=%h expected=%h",
               tag, v.rn, v.rd, v.a, got, exp);
    end
  endtask

  task automatic apply(input logic rn, input logic rd, input logic [15:0] a);
    rst_ni = rn; rd_i = rd; addr_i = a;
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    vec_t v;
    apply(1'b0, 1'b1, 16'h0000);
    // reset state: address 0 under reset decodes to RAM (R4, R1)
    model(1'b0, 1'b1, 16'h0000, v);
    check(v, "R4");

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].rn, TBL[i].rd, TBL[i].a);
      check(TBL[i], tag_of(TBL[i].dev, TBL[i].rn, TBL[i].rd, TBL[i].a));
    end

    // full sweeps, R1..R8, both reset levels and both directions
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 2; d++) begin
        for (int a = 0; a < 65536; a++) begin
          apply(r[0], d[0], a[15:0]);
          model(r[0], d[0], a[15:0], v);
          check(v, tag_of(v.dev, v.rn, v.rd, v.a));
        end
      end
    end

    // R5: release reset mid-cycle with reset vector on the bus, no clock needed
    @(negedge clk);
    apply(1'b0, 1'b1, 16'hFFFD);
    model(1'b0, 1'b1, 16'hFFFD, v);
    check(v, "R5");
    rst_ni = 1'b1;
    #1;
    model(1'b1, 1'b1, 16'hFFFD, v);
    check(v, "R5");
    rst_ni = 1'b0;
    #1;
    model(1'b0, 1'b1, 16'hFFFD, v);
    check(v, "R5");

    finish_run();
  end
endmodule